// File: doc/BRIEF.md
# Double-Buffered Asymmetric PWM Generator

This block produces one pulse-width-modulated output from an up-counter that runs from zero to a programmable period value and then wraps. A period therefore lasts period+1 clock cycles. While the counter is below the compare value the output sits at its active level. A polarity input chooses whether that level is high or low. The encoding gives exact 0% duty when compare is zero and exact 100% duty when compare is period+1 or larger.

Period and compare each have an active register and a shadow register, both loaded through one write port. A write to an active register also loads its shadow, so the value applies from the next counter wrap. A write to a shadow register is held until the period-match cycle, which is when the counter equals the period. On that cycle the shadow moves into the active register. A value that reaches an active register is not used by the counter or the comparator until the following wrap. This means a pulse is never cut short partway through a period. Software normally loads both active registers once during setup and then changes only the shadows.

Top module: `shpwm_top`

## Requirements
- R1: After reset the counter and all period and compare registers are zero. With the block enabled it then gives a constant inactive output, which is low for pol=0 and high for pol=1.
- R2: When enabled, the counter counts 0, 1, ..., P and then returns to 0. P is the period in use, so each PWM period lasts P+1 cycles.
- R3: With compare = 0 the output stays at its inactive level for the whole period (0% duty).
- R4: With 1 <= compare = N <= P the output is active for the first N cycles of each period, while the counter is below N. Compare = P therefore leaves exactly one inactive cycle.
- R5: With compare >= P+1 the output is active for every cycle of the period (100% duty).
- R6: pol=1 inverts the output. The active level is low and the inactive level is high.
- R7: Write select codes are 00 active period, 01 active compare, 10 shadow period and 11 shadow compare. A write to an active register also loads the same value into its shadow.
- R8: A write to a shadow register leaves the active register unchanged until the next period-match cycle, which then copies the shadow into the active register. A shadow write made in the period-match cycle itself is the value copied.
- R9: The counter and comparator use a new active value only from the next wrap, so the period in progress completes with the old values.
- R10: While en is low the counter is held at 0 and the output is at its inactive level. No shadow transfer takes place, and counting resumes from 0 with the current active values.
- R11: Period and compare have separate transfer paths. A shadow write to one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| pol | input | 1 | Output polarity, 0 active high, 1 active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 act period, 01 act compare, 10 shadow period, 11 shadow compare |
| wr_data | input | 32 | Write value |
| pwm_out | output | 1 | PWM output |

## Verification
Directed compare values are 0, 1, an interior value, P, P+1 and well above P. Each of these is run under both polarities, which separates the 0%, exact-N, one-inactive-cycle and 100% cases. Shadow writes are placed partway through a period and also exactly on the period-match cycle. This distinguishes deferred transfer from immediate transfer and shows whether the value written in the match cycle is forwarded. Active writes followed by a period match show the mirror into the shadow: without it, the stale shadow would overwrite the new value. Random write sequences with small periods, random polarity and enable drops then exercise interactions of wrap timing, transfer and disable across many periods.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;
    typedef enum logic [1:0] {
        SEL_ACT_PRD = 2'b00,
        SEL_ACT_CMP = 2'b01,
        SEL_SHD_PRD = 2'b10,
        SEL_SHD_CMP = 2'b11
    } wsel_e;

    localparam int unsigned NUM_REGS = 2;
endpackage

// File: rtl/shpwm_regbank.sv
module shpwm_regbank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_act,
    input  logic         wr_shd,
    input  logic [W-1:0] wr_data,
    input  logic         xfer,
    input  logic         load_live,
    output logic [W-1:0] act_o,
    output logic [W-1:0] shd_o,
    output logic [W-1:0] live_o
);
    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] shd;
        logic [W-1:0] live;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_act || wr_shd) begin
            s_d.shd = wr_data;
        end
        if (wr_act) begin
            s_d.act = wr_data;
        end else if (xfer) begin
            s_d.act = s_d.shd;
        end
        if (load_live) begin
            s_d.live = s_d.act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o  = s_q.act;
    assign shd_o  = s_q.shd;
    assign live_o = s_q.live;

    AST_MIRROR_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> (act_o == shd_o)); // R7

    AST_SHADOW_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_shd && !xfer) |=> $stable(act_o)); // R8

    AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_live |=> $stable(live_o)); // R9
endmodule

// File: rtl/shpwm_counter.sv
module shpwm_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] prd_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    assign match_o = en && (s_q.cnt == prd_i);

    always_comb begin
        s_d = s_q;
        if (!en || match_o) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= prd_i); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> (cnt_o == '0)); // R2

    AST_IDLE_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_o == '0)); // R10
endmodule

// File: rtl/shpwm_outstage.sv
module shpwm_outstage #(
    parameter int unsigned W = 32
) (
    input  logic         en,
    input  logic         pol,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    output logic         pwm_o
);
    logic active_d;

    always_comb begin
        active_d = en && (cnt_i < cmp_i);
        pwm_o    = active_d ^ pol;
    end
endmodule

// File: rtl/shpwm_top.sv
module shpwm_top #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         pol,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out
);
    import shpwm_pkg::*;

    localparam int unsigned IDX_PRD = 0;
    localparam int unsigned IDX_CMP = 1;

    logic [W-1:0] act_q  [NUM_REGS];
    logic [W-1:0] shd_q  [NUM_REGS];
    logic [W-1:0] live_q [NUM_REGS];
    logic [W-1:0] cnt_q;
    logic         match;
    logic         load_live;

    assign load_live = match || !en;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        logic wr_act_d, wr_shd_d;
        always_comb begin
            wr_act_d = wr_en && (wr_sel == {1'b0, 1'(g)});
            wr_shd_d = wr_en && (wr_sel == {1'b1, 1'(g)});
        end
        shpwm_regbank #(.W(W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_act    (wr_act_d),
            .wr_shd    (wr_shd_d),
            .wr_data   (wr_data),
            .xfer      (match),
            .load_live (load_live),
            .act_o     (act_q[g]),
            .shd_o     (shd_q[g]),
            .live_o    (live_q[g])
        );
    end

    shpwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .prd_i   (live_q[IDX_PRD]),
        .cnt_o   (cnt_q),
        .match_o (match)
    );

    shpwm_outstage #(.W(W)) u_out (
        .en    (en),
        .pol   (pol),
        .cnt_i (cnt_q),
        .cmp_i (live_q[IDX_CMP]),
        .pwm_o (pwm_out)
    );

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ({1'b0, live_q[IDX_CMP]} > {1'b0, live_q[IDX_PRD]})) |-> (pwm_out != pol)); // R5

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && live_q[IDX_CMP] == '0) |-> (pwm_out == pol)); // R3

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pwm_out == pol)); // R10

    AST_PRD_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11) |=> $stable(shd_q[IDX_PRD])); // R11
endmodule

// File: tb/shpwm_top_bench.sv
module shpwm_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        pol = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [31:0] wr_data = '0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    logic [31:0] m_act [2];
    logic [31:0] m_shd [2];
    logic [31:0] m_live[2];
    logic [31:0] m_cnt;

    always #5 clk = ~clk;

    shpwm_top u_shpwm_top (
        .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    function automatic string case_tag(logic e, logic p);
        if (!e) return "R10";
        if (p) return "R6";
        if (m_live[1] == 0) return "R3";
        if ({1'b0, m_live[1]} > {1'b0, m_live[0]}) return "R5";
        return "R4";
    endfunction

    function automatic logic exp_out(logic e, logic p);
        if (!e) return p;
        return (m_cnt < m_live[1]) ^ p;
    endfunction

    task automatic tick(input logic e, input logic p, input logic we,
                        input logic [1:0] ws, input logic [31:0] wd);
        logic exp;
        logic hit;
        logic [31:0] nact[2];
        logic [31:0] nshd[2];
        @(negedge clk);
        en = e; pol = p; wr_en = we; wr_sel = ws; wr_data = wd;
        #1;
        exp = exp_out(e, p);
        checks++;
        if (pwm_out !== exp) begin
            errors++;
            $display("FAIL %s %s cnt=%0d prd=%0d cmp=%0d actual=%b expected=%b",
                     case_tag(e, p), phase, m_cnt, m_live[0], m_live[1], pwm_out, exp);
        end
        hit = e && (m_cnt == m_live[0]);
        for (int i = 0; i < 2; i++) begin
            logic wa, wsh;
            wa  = we && ws == {1'b0, 1'(i)};
            wsh = we && ws == {1'b1, 1'(i)};
            nshd[i] = (wa || wsh) ? wd : m_shd[i];
            nact[i] = wa ? wd : (hit ? nshd[i] : m_act[i]);
        end
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            m_shd[i] = nshd[i];
            m_act[i] = nact[i];
            if (hit || !e) m_live[i] = nact[i];
        end
        m_cnt = (!e || hit) ? 32'd0 : m_cnt + 1;
    endtask

    task automatic run(input int n, input logic p);
        for (int k = 0; k < n; k++) tick(1'b1, p, 1'b0, 2'b00, 32'd0);
    endtask

    task automatic wr(input logic p, input logic [1:0] ws, input logic [31:0] wd);
        tick(1'b1, p, 1'b1, ws, wd);
    endtask

    task automatic wait_match(input logic p);
        int guard = 0;
        while (m_cnt != m_live[0] && guard < 100000) begin
            tick(1'b1, p, 1'b0, 2'b00, 32'd0);
            guard++;
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int seed = 32'h5eed_1234;
        int dummy;
        dummy = $urandom(seed);
        for (int i = 0; i < 2; i++) begin
            m_act[i] = 0; m_shd[i] = 0; m_live[i] = 0;
        end
        m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        run(4, 1'b0);
        run(4, 1'b1);

        phase = "R2_R3";
        wr(1'b0, 2'b00, 32'd9);
        wr(1'b0, 2'b01, 32'd0);
        run(25, 1'b0);

        phase = "R4_R9";
        for (int v = 1; v <= 10; v++) begin
            wr(1'b0, 2'b01, 32'(v));
            run(23, 1'b0);
        end
        phase = "R5";
        wr(1'b0, 2'b01, 32'd50);
        run(22, 1'b0);
        wr(1'b0, 2'b01, 32'hFFFF_FFFF);
        run(22, 1'b0);

        phase = "R6";
        foreach (m_act[i]) begin end
        wr(1'b1, 2'b01, 32'd0);  run(22, 1'b1);
        wr(1'b1, 2'b01, 32'd3);  run(22, 1'b1);
        wr(1'b1, 2'b01, 32'd9);  run(22, 1'b1);
        wr(1'b1, 2'b01, 32'd10); run(22, 1'b1);

        phase = "R8_mid";
        wr(1'b0, 2'b01, 32'd2);
        run(12, 1'b0);
        run(3, 1'b0);
        wr(1'b0, 2'b11, 32'd7);
        run(25, 1'b0);

        phase = "R8_on_match";
        wait_match(1'b0);
        wr(1'b0, 2'b11, 32'd4);
        run(25, 1'b0);

        phase = "R7";
        wr(1'b0, 2'b11, 32'd8);
        wr(1'b0, 2'b01, 32'd1);
        run(30, 1'b0);

        phase = "R11";
        wr(1'b0, 2'b10, 32'd5);
        run(20, 1'b0);
        wr(1'b0, 2'b11, 32'd6);
        run(20, 1'b0);

        phase = "R10";
        run(3, 1'b0);
        for (int k = 0; k < 5; k++) tick(1'b0, 1'b0, 1'b0, 2'b00, 32'd0);
        tick(1'b0, 1'b1, 1'b1, 2'b11, 32'd2);
        tick(1'b0, 1'b1, 1'b0, 2'b00, 32'd0);
        run(20, 1'b0);

        phase = "R2_prd0";
        wr(1'b0, 2'b00, 32'd0);
        wr(1'b0, 2'b01, 32'd1);
        run(8, 1'b0);
        wr(1'b0, 2'b01, 32'd0);
        run(8, 1'b0);

        phase = "random";
        for (int k = 0; k < 4000; k++) begin
            logic e, p, we;
            e  = ($urandom % 16) != 0;
            p  = ($urandom % 400) < 200 ? pol : ~pol;
            we = ($urandom % 6) == 0;
            tick(e, p, we, 2'($urandom), $urandom % 24);
        end

        summary();
    end
endmodule